// File: doc/BRIEF.md
# Audio Converter Clock Generator

This block produces the three clocks that a stereo audio converter expects, working from a single 25 MHz system clock. The master clock must be about 12.288 MHz, which is 256 times a 48 kHz sample rate. 25 MHz does not divide to that rate by any integer, so the master clock is taken from the top bit of a phase accumulator. The accumulator adds a fixed fractional step on every system cycle.

Every master-clock rising edge is detected in the system-clock domain and advances a small cycle counter. One bit of that counter is the serial bit clock, at one quarter of the master rate (64 times the sample rate). The top bit is the left/right frame clock, at 1/256 of the master rate. Both come from the same counter, so they stay phase-locked to each other.

Two one-cycle strobes in the system domain let downstream logic act on a bit-clock rising edge or on a frame change without running its own edge detector.

Top module: `audio_clk_gen`

## Requirements
- R1: While `rst_sys` is high, and in the first system cycle after it is released, `mclk_o`, `bclk_o`, `lrclk_o`, `bclk_rise_o` and `lrclk_tgl_o` are all 0, and counting restarts from zero.
- R2: `mclk_o` is bit 31 of a 32-bit accumulator that adds INC = round(MCLK_HZ·2^32/SYS_HZ) every cycle (2111062325 with the defaults). After N clock edges since reset, the number of `mclk_o` rising edges is floor((N·INC + 2^31)/2^32).
- R3: With the defaults, each high phase and each low phase of `mclk_o` lasts 1 or 2 system cycles.
- R4: Over N system cycles from reset, the count of master-clock periods is within ±1 of N·MCLK_HZ/SYS_HZ. For N = 100000 this is 49152.
- R5: A cycle counter advances one system cycle after each `mclk_o` rising edge. `bclk_o` equals its bit 1, so after R master rising edges `bclk_o` = (R>>1)&1.
- R6: `lrclk_o` equals bit 7 of the same counter, (R>>7)&1. It is 1 for the left channel and 0 for the right channel. It changes only in a cycle in which `bclk_o` falls.
- R7: `bclk_rise_o` is high for exactly one cycle, the first system cycle in which `bclk_o` is high. After R master edges its total count is floor((R+2)/4).
- R8: `lrclk_tgl_o` is high exactly in the system cycle in which `lrclk_o` takes a new value. After R master edges its total count is floor(R/128).
- R9: A synchronous reset applied mid-run returns every output to its R1 state, and the R2 counts then restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | 25 MHz system clock |
| rst_sys | input | 1 | Synchronous reset, active high |
| mclk_o | output | 1 | Approximate 12.288 MHz master clock |
| bclk_o | output | 1 | Serial bit clock, master / 4 |
| lrclk_o | output | 1 | Frame clock, master / 256, 1 = left |
| bclk_rise_o | output | 1 | One-cycle strobe on each bit-clock rising edge |
| lrclk_tgl_o | output | 1 | One-cycle strobe on each frame-clock change |

## Verification
The assertions check these rules on every cycle:
- the master clock never holds a level for more than two cycles;
- the bit clock changes only one cycle after a master rising edge;
- the frame clock moves only together with a bit-clock fall;
- each strobe coincides exactly with the edge it marks;
- all outputs are low after reset.

Only the bench scenarios can show the absolute counts: how many master edges, bit-clock edges and frame changes there are at chosen points in time, the long-run ±1 rate, and the restart after a mid-run reset.

// File: rtl/acg_pkg.sv
package acg_pkg;

   // Rounded fractional step for a phase accumulator of width w.
   function automatic logic [63:0] calc_incr(input longint unsigned sys_hz,
                                             input longint unsigned out_hz,
                                             input int unsigned     w);
      longint unsigned num;
      num = (out_hz << w) + (sys_hz / 2);
      return num / sys_hz;
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/acg_phase_acc.sv
module acg_phase_acc #(
   parameter int unsigned           ACC_W = 32,
   parameter logic [ACC_W-1:0]      STEP  = '0
) (
   input  logic clk,
   input  logic rst,
   output logic tone
);

   logic [ACC_W-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (rst) phase_q <= '0;
      else     phase_q <= phase_q + STEP;
   end

   assign tone = phase_q[ACC_W-1];

endmodule

// File: rtl/acg_rise_det.sv
module acg_rise_det (
   input  logic clk,
   input  logic rst,
   input  logic sig,
   output logic rise
);

   logic sig_q;

   always_ff @(posedge clk) begin
      if (rst) sig_q <= 1'b0;
      else     sig_q <= sig;
   end

   assign rise = sig & ~sig_q;

endmodule

// File: rtl/acg_div_counter.sv
module acg_div_counter #(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned SLOW_B  = 1,
   parameter int unsigned FRAME_B = 7
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   output logic slow_clk,
   output logic frame_clk,
   output logic slow_rise,
   output logic frame_tgl
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             rise_q;
   logic             tgl_q;

   assign cnt_nxt = cnt_q + CNT_W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         rise_q <= 1'b0;
         tgl_q  <= 1'b0;
      end else begin
         rise_q <= adv & ~cnt_q[SLOW_B] & cnt_nxt[SLOW_B];
         tgl_q  <= adv & (cnt_q[FRAME_B] ^ cnt_nxt[FRAME_B]);
         if (adv) cnt_q <= cnt_nxt;
      end
   end

   assign slow_clk  = cnt_q[SLOW_B];
   assign frame_clk = cnt_q[FRAME_B];
   assign slow_rise = rise_q;
   assign frame_tgl = tgl_q;

endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen #(
   parameter longint unsigned SYS_HZ    = 25_000_000,
   parameter longint unsigned MCLK_HZ   = 12_288_000,
   parameter int unsigned     ACC_W     = 32,
   parameter int unsigned     BCLK_DIV  = 4,
   parameter int unsigned     FRAME_DIV = 256
) (
   input  logic clk_sys,
   input  logic rst_sys,
   output logic mclk_o,
   output logic bclk_o,
   output logic lrclk_o,
   output logic bclk_rise_o,
   output logic lrclk_tgl_o
);

   import acg_pkg::*;

   localparam logic [63:0]      INC_FULL = calc_incr(SYS_HZ, MCLK_HZ, ACC_W);
   localparam logic [ACC_W-1:0] INC      = INC_FULL[ACC_W-1:0];
   localparam int unsigned      CNT_W    = $clog2(FRAME_DIV);
   localparam int unsigned      SLOW_B   = $clog2(BCLK_DIV) - 1;
   localparam int unsigned      FRAME_B  = CNT_W - 1;

   generate
      if (ACC_W < 8 || ACC_W > 48) begin : g_bad_acc
         $error("accumulator width out of range");
      end
      if (MCLK_HZ * 2 >= SYS_HZ) begin : g_bad_ratio
         $error("master clock must be below half the system clock");
      end
      if (!is_pow2(BCLK_DIV) || BCLK_DIV < 2) begin : g_bad_bdiv
         $error("bit clock divider must be a power of two >= 2");
      end
      if (!is_pow2(FRAME_DIV) || FRAME_DIV <= BCLK_DIV) begin : g_bad_fdiv
         $error("frame divider must be a power of two above the bit divider");
      end
   endgenerate

   logic mclk;
   logic mrise;

   acg_phase_acc #(
      .ACC_W (ACC_W),
      .STEP  (INC)
   ) i_acc (
      .clk  (clk_sys),
      .rst  (rst_sys),
      .tone (mclk)
   );

   acg_rise_det i_rise (
      .clk  (clk_sys),
      .rst  (rst_sys),
      .sig  (mclk),
      .rise (mrise)
   );

   acg_div_counter #(
      .CNT_W   (CNT_W),
      .SLOW_B  (SLOW_B),
      .FRAME_B (FRAME_B)
   ) i_div (
      .clk       (clk_sys),
      .rst       (rst_sys),
      .adv       (mrise),
      .slow_clk  (bclk_o),
      .frame_clk (lrclk_o),
      .slow_rise (bclk_rise_o),
      .frame_tgl (lrclk_tgl_o)
   );

   assign mclk_o = mclk;

endmodule

// File: rtl/audio_clk_gen_chk.sv
module audio_clk_gen_chk (
   input logic clk,
   input logic rst,
   input logic mclk,
   input logic bclk,
   input logic lrclk,
   input logic bstb,
   input logic lstb
);

   // R1
   reset_low_chk: assert property (@(posedge clk)
      $past(rst) |-> (!mclk && !bclk && !lrclk && !bstb && !lstb));

   // R3
   mclk_high_len_chk: assert property (@(posedge clk) disable iff (rst)
      (mclk && $past(mclk) && !$past(rst, 2)) |-> !$past(mclk, 2));

   // R3
   mclk_low_len_chk: assert property (@(posedge clk) disable iff (rst)
      (!mclk && !$past(mclk) && !$past(rst) && !$past(rst, 2)) |-> $past(mclk, 2));

   // R5
   bclk_after_mrise_chk: assert property (@(posedge clk) disable iff (rst)
      (bclk != $past(bclk)) |-> ($past(mclk) && !$past(mclk, 2)));

   // R6
   lr_on_bclk_fall_chk: assert property (@(posedge clk) disable iff (rst)
      (lrclk != $past(lrclk)) |-> $fell(bclk));

   // R7
   bstb_marks_rise_chk: assert property (@(posedge clk) disable iff (rst)
      bstb == (bclk && !$past(bclk)));

   // R8
   lstb_marks_tgl_chk: assert property (@(posedge clk) disable iff (rst)
      lstb == (lrclk != $past(lrclk)));

endmodule

bind audio_clk_gen audio_clk_gen_chk i_chk (
   .clk   (clk_sys),
   .rst   (rst_sys),
   .mclk  (mclk_o),
   .bclk  (bclk_o),
   .lrclk (lrclk_o),
   .bstb  (bclk_rise_o),
   .lstb  (lrclk_tgl_o)
);

// File: tb/test_audio_clk_gen.sv
module test_audio_clk_gen;

   localparam longint unsigned STEP = 64'd2111062325;
   localparam longint unsigned HALF = 64'd2147483648;
   localparam longint unsigned FULL = 64'd4294967296;
   localparam int NPTS = 13;
   localparam int unsigned CKPT [NPTS] = '{1, 2, 3, 4, 9, 40, 130, 270,
                                           530, 1041, 4100, 20000, 100000};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic mclk, bclk, lrclk, bstb, lstb;

   int checks = 0;
   int errors = 0;
   longint unsigned k, mrise, bcount, fcount;
   logic mprev, bprev, lprev;
   int bad_bstb, bad_lr;
   bit done = 0;

   always #5 clk = ~clk;

   audio_clk_gen i_audio_clk_gen (
      .clk_sys     (clk),
      .rst_sys     (rst),
      .mclk_o      (mclk),
      .bclk_o      (bclk),
      .lrclk_o     (lrclk),
      .bclk_rise_o (bstb),
      .lrclk_tgl_o (lstb)
   );

   function automatic longint unsigned rises(input longint unsigned n);
      return (n * STEP + HALF) / FULL;
   endfunction

   task automatic chk(input string req, input longint unsigned act,
                      input longint unsigned exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_counts();
      k = 0; mrise = 0; bcount = 0; fcount = 0;
      mprev = 0; bprev = 0; lprev = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      k++;
      if (mclk && !mprev) mrise++;
      if (bstb) bcount++;
      if (lstb) fcount++;
      if (bstb != (bclk && !bprev)) bad_bstb++;
      if ((lrclk != lprev) && !(bprev && !bclk)) bad_lr++;
      mprev = mclk; bprev = bclk; lprev = lrclk;
   endtask

   task automatic check_point(input longint unsigned n);
      longint unsigned r;
      r = rises(n - 1);
      chk("R2 mclk rises", mrise, rises(n));
      chk("R5 bclk level", longint'(bclk), (r >> 1) & 1);
      chk("R6 lrclk level", longint'(lrclk), (r >> 7) & 1);
      chk("R7 bclk strobes", bcount, (r + 2) / 4);
      chk("R8 frame strobes", fcount, r / 128);
   endtask

   initial begin
      bad_bstb = 0; bad_lr = 0;
      clear_counts();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 reset outputs", longint'({mclk, bclk, lrclk, bstb, lstb}), 0);
      rst = 1'b0;
      for (int i = 0; i < NPTS; i++) begin
         while (k < CKPT[i]) tick();
         if (i == 0)
            chk("R1 first cycle outputs", longint'({mclk, bclk, lrclk, bstb, lstb}), 0);
         check_point(CKPT[i]);
      end
      // R4 long-run rate: 100000 cycles -> 49152 +/- 1
      checks++;
      if (mrise < 49151 || mrise > 49153) begin
         errors++;
         $display("FAIL R4 rate actual=%0d expected=49152+/-1", mrise);
      end
      chk("R7 strobe alignment violations", bad_bstb, 0);
      chk("R6 frame change off bclk fall", bad_lr, 0);
      // R9 mid-run reset
      @(posedge clk);
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R9 outputs in reset", longint'({mclk, bclk, lrclk, bstb, lstb}), 0);
      rst = 1'b0;
      clear_counts();
      while (k < 300) tick();
      check_point(300);
      chk("R9 strobe alignment after reset", bad_bstb, 0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule